// File: doc/BRIEF.md
# Error Position Search Engine

This block scans a sector for bit-error positions, given the error-locator polynomial that a separate solver has already computed over GF(2^13). Software loads the polynomial coefficients and the degree into registers, then writes the search length to a start register. The engine then tests one candidate position per clock, counting from 1. Each candidate whose polynomial value is zero is recorded in a list of position registers. When the last candidate has been tested, the engine raises a done flag, and the status register shows how many roots were found.

The consumer turns a recorded position p into a byte index (p-1)/8 and a bit index (p-1) mod 8. It treats the sector as correctable only when the root count equals the loaded degree. The count saturates one above the degree, so an all-zero or otherwise broken polynomial still shows up as a mismatch. A stop register aborts a search that is under way.

Top module: `err_locator_search`

## Requirements
- R1: After reset the status register (word 0x03) reads 0 and `search_done` is low.
- R2: Register map (word addresses): 0x00 config, with the sector-size select in bit 0 and the polynomial degree in bits 20:16. 0x01 start: a write starts a search, and bits 15:0 give the length. 0x02 stop. 0x03 status. 0x10+k coefficient k (13 bits, k = 0..MAX_T). 0x20+i position register i. Config and coefficients read back what was written, one cycle after `rd_en`.
- R3: A search of length L tests positions n = 1..L in ascending order. Position n is a root when the sum over k = 0..deg of sigma_k·alpha^(k·n) is 0, where alpha is a root of the field polynomial x^13+x^4+x^3+x+1. Roots fill position registers 0, 1, 2, … in the order they are found, and each holds n itself, counting from 1.
- R4: `search_done` and status bit 0 rise exactly L clock cycles after the clock edge that takes the start write (L ≥ 1). Status bit 1 (busy) is high while the search runs.
- R5: Status bits 12:8 hold the number of roots found. The count stops at deg+1. Only the first min(count, MAX_T) roots are stored.
- R6: Coefficients with index above the loaded degree do not affect which positions are roots.
- R7: A start write clears done and the root count at the next edge. A start write during a search restarts the search with the new length.
- R8: A write of 1 to bit 0 of the stop register ends any search and clears busy, done and the count. No done follows the aborted search.
- R9: A start write with length 0 sets done at the next edge, with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| search_done | output | 1 | Search finished (mirrors status bit 0) |

## Verification
The bench sets the exact cycle of the done flag against the length. A design that is off by one in its position counter, or that evaluates position 0, either raises done a cycle early or late, or reports every root shifted by one. Stale coefficients above the degree are loaded with random non-zero values, and a design that does not mask them finds the wrong roots. An all-zero polynomial makes every position a root, which exposes a count that does not stop at deg+1 or a store that overruns the position list. Length 0, a stop in mid-search and a restart while busy each check that done neither appears late nor lingers.

// File: rtl/els_pkg.sv
package els_pkg;
  localparam int GF_M = 13;
  // low terms of x^13 + x^4 + x^3 + x + 1
  localparam logic [GF_M-1:0] GF_POLY_LOW = 13'h001B;
  typedef logic [GF_M-1:0] gf_t;

  localparam logic [5:0] A_CFG    = 6'h00;
  localparam logic [5:0] A_START  = 6'h01;
  localparam logic [5:0] A_STOP   = 6'h02;
  localparam logic [5:0] A_STATUS = 6'h03;
  localparam logic [1:0] REG_SIGMA = 2'b01;
  localparam logic [1:0] REG_POS   = 2'b10;

  function automatic gf_t gf_mulx(gf_t x);
    return {x[GF_M-2:0], 1'b0} ^ (x[GF_M-1] ? GF_POLY_LOW : '0);
  endfunction

  // multiply by alpha^k with a chain of k shift-reduce steps (k is a constant)
  function automatic gf_t gf_mul_apow(gf_t x, int k);
    gf_t r;
    r = x;
    for (int i = 0; i < k; i++) r = gf_mulx(r);
    return r;
  endfunction
endpackage

// File: rtl/els_term_bank.sv
module els_term_bank
  import els_pkg::*;
#(
  parameter int MAX_T = 8,
  parameter int DEG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 step,
  input  gf_t [MAX_T:0]        sigma_i,
  input  logic [DEG_W-1:0]     deg_i,
  output logic                 is_root_o
);
  gf_t [MAX_T:0] term_q;
  gf_t [MAX_T:0] term_act;

  for (genvar k = 0; k <= MAX_T; k++) begin : g_term
    always_ff @(posedge clk) begin
      if (rst)       term_q[k] <= '0;
      else if (load) term_q[k] <= gf_mul_apow(sigma_i[k], k);
      else if (step) term_q[k] <= gf_mul_apow(term_q[k], k);
    end
    assign term_act[k] = (k <= int'(deg_i)) ? term_q[k] : '0;
  end

  always_comb begin
    gf_t acc;
    acc = '0;
    for (int k = 0; k <= MAX_T; k++) acc = acc ^ term_act[k];
    is_root_o = (acc == '0);
  end
endmodule

// File: rtl/els_pos_store.sv
module els_pos_store #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/err_locator_search.sv
module err_locator_search
  import els_pkg::*;
#(
  parameter int MAX_T  = 8,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              search_done
);
  localparam int DEG_W = $clog2(MAX_T + 2);
  localparam int IDX_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  gf_t [MAX_T:0]      sigma_q;
  logic               sect_q;
  logic [DEG_W-1:0]   cfg_deg_q, deg_run_q;
  logic [LEN_W-1:0]   len_q, cur_q;
  logic [DEG_W-1:0]   cnt_q;
  logic               busy_q, done_q;
  logic [DATA_W-1:0]  reg_rd_q;
  logic               rd_pos_q;
  logic [LEN_W-1:0]   pos_rd;
  logic               is_root;

  logic [3:0] sub_idx;
  logic       start_wr, stop_wr, sig_hit, pos_hit, pos_we, cnt_open;

  assign sub_idx  = addr[3:0];
  assign start_wr = wr_en && (addr == A_START);
  assign stop_wr  = wr_en && (addr == A_STOP) && wdata[0];
  assign sig_hit  = (addr[5:4] == REG_SIGMA) && (int'(sub_idx) <= MAX_T);
  assign pos_hit  = (addr[5:4] == REG_POS) && (int'(sub_idx) < MAX_T);
  assign cnt_open = (cnt_q <= deg_run_q);
  assign pos_we   = busy_q && !start_wr && !stop_wr && is_root && cnt_open &&
                    (int'(cnt_q) < MAX_T);

  // configuration and coefficient registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sigma_q   <= '0;
      sect_q    <= 1'b0;
      cfg_deg_q <= '0;
    end else if (wr_en) begin
      if (addr == A_CFG) begin
        sect_q    <= wdata[0];
        cfg_deg_q <= wdata[16 +: DEG_W];
      end
      if (sig_hit) sigma_q[sub_idx] <= wdata[GF_M-1:0];
    end
  end

  // search sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
      len_q <= '0; cur_q <= '0; deg_run_q <= '0;
    end else if (stop_wr) begin
      busy_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
    end else if (start_wr) begin
      len_q     <= wdata[LEN_W-1:0];
      cur_q     <= LEN_W'(1);
      cnt_q     <= '0;
      deg_run_q <= cfg_deg_q;
      busy_q    <= |wdata[LEN_W-1:0];
      done_q    <= ~|wdata[LEN_W-1:0];
    end else if (busy_q) begin
      if (is_root && cnt_open) cnt_q <= cnt_q + 1'b1;
      if (cur_q == len_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cur_q <= cur_q + 1'b1;
      end
    end
  end

  els_term_bank #(.MAX_T(MAX_T), .DEG_W(DEG_W)) u_terms (
    .clk(clk), .rst(rst),
    .load(start_wr && !stop_wr), .step(busy_q),
    .sigma_i(sigma_q), .deg_i(deg_run_q), .is_root_o(is_root)
  );

  els_pos_store #(.DEPTH(MAX_T), .W(LEN_W)) u_pos (
    .clk(clk), .we(pos_we), .widx(cnt_q[IDX_W-1:0]), .wdata(cur_q),
    .re(rd_en && pos_hit), .ridx(sub_idx[IDX_W-1:0]), .rdata(pos_rd)
  );

  // register read path, one cycle of latency
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      rd_pos_q <= 1'b0;
    end else if (rd_en) begin
      rd_pos_q <= pos_hit;
      reg_rd_q <= '0;
      if (addr == A_CFG) begin
        reg_rd_q[0]           <= sect_q;
        reg_rd_q[16 +: DEG_W] <= cfg_deg_q;
      end else if (addr == A_START) begin
        reg_rd_q[LEN_W-1:0] <= len_q;
      end else if (addr == A_STATUS) begin
        reg_rd_q[0]          <= done_q;
        reg_rd_q[1]          <= busy_q;
        reg_rd_q[8 +: DEG_W] <= cnt_q;
      end else if (sig_hit) begin
        reg_rd_q[GF_M-1:0] <= sigma_q[sub_idx];
      end
    end
  end

  assign rdata       = rd_pos_q ? DATA_W'(pos_rd) : reg_rd_q;
  assign search_done = done_q;

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt_q} <= {1'b0, deg_run_q} + 1'b1);
  // R4
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_q && busy_q));
  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> (!busy_q && !done_q && cnt_q == '0));
  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !stop_wr) |=> (cnt_q == '0 && (busy_q != done_q)));
  // R3
  cur_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cur_q >= LEN_W'(1) && cur_q <= len_q));
  // R4
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(busy_q) || $past(start_wr)));
endmodule

// File: tb/err_locator_search_tb.sv
module err_locator_search_tb;
  localparam int MAX_T = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        search_done;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [12:0] sg [0:MAX_T];
  int exp_pos [0:MAX_T];

  always #2.5 clk = ~clk;

  err_locator_search #(.MAX_T(MAX_T)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .search_done(search_done)
  );

  function automatic logic [12:0] mulx(logic [12:0] x);
    return {x[11:0], 1'b0} ^ (x[12] ? 13'h001B : 13'h0);
  endfunction
  function automatic logic [12:0] gmul(logic [12:0] a, logic [12:0] b);
    logic [12:0] r = '0;
    for (int i = 12; i >= 0; i--) begin
      r = mulx(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction
  function automatic logic [12:0] apow(int n);
    logic [12:0] r = 13'h1;
    for (int i = 0; i < n; i++) r = mulx(r);
    return r;
  endfunction
  function automatic logic [12:0] eval_at(int deg, int n);
    logic [12:0] beta = apow(n), p = 13'h1, acc = '0;
    for (int k = 0; k <= deg; k++) begin
      acc = acc ^ gmul(sg[k], p);
      p = gmul(p, beta);
    end
    return acc;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rdata;
  endtask

  // start a search and check the exact done cycle (R4, R9)
  task automatic start_and_wait(int len);
    wr(6'h01, 32'(len));
    if (len == 0) begin
      chk(search_done == 1'b1, "R9 done after zero length", int'(search_done), 1);
    end else begin
      chk(search_done == 1'b0, "R7 done cleared by start", int'(search_done), 0);
      repeat (len - 1) @(posedge clk);
      #1 chk(search_done == 1'b0, "R4 done not early", int'(search_done), 0);
      @(posedge clk); #1;
      chk(search_done == 1'b1, "R4 done at length", int'(search_done), 1);
    end
  endtask

  task automatic load_poly(int deg, int sect);
    for (int k = 0; k <= MAX_T; k++) wr(6'h10 + 6'(k), {19'b0, sg[k]});
    wr(6'h00, (32'(deg) << 16) | 32'(sect));
  endtask

  // full trial: expected roots from direct polynomial evaluation (R3, R5, R6)
  task automatic trial(int deg, int len);
    int nfound = 0, ecnt, nstore;
    logic [31:0] d;
    for (int n = 1; n <= len; n++)
      if (eval_at(deg, n) == 13'h0) begin
        if (nfound < MAX_T + 1) exp_pos[nfound] = n;
        nfound++;
      end
    ecnt = (nfound > deg + 1) ? deg + 1 : nfound;
    nstore = (ecnt > MAX_T) ? MAX_T : ecnt;
    load_poly(deg, deg & 1);
    start_and_wait(len);
    rd(6'h03, d);
    chk(d[12:8] == 5'(ecnt), "R5 root count", int'(d[12:8]), ecnt);
    chk(d[1:0] == 2'b01, "R4 status done not busy", int'(d[1:0]), 1);
    for (int i = 0; i < nstore; i++) begin
      rd(6'h20 + 6'(i), d);
      chk(d == 32'(exp_pos[i]), "R3 position register", int'(d), exp_pos[i]);
    end
  endtask

  task automatic build_from_roots(int deg, int roots[]);
    logic [12:0] nw [0:MAX_T];
    for (int k = 0; k <= MAX_T; k++) sg[k] = '0;
    sg[0] = 13'h1;
    for (int i = 0; i < deg; i++) begin
      logic [12:0] r = apow(roots[i]);
      for (int k = 0; k <= MAX_T; k++)
        nw[k] = gmul(r, sg[k]) ^ ((k > 0) ? sg[k-1] : 13'h0);
      for (int k = 0; k <= MAX_T; k++) sg[k] = nw[k];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk(search_done == 1'b0, "R1 done low after reset", int'(search_done), 0);
    rd(6'h03, d);
    chk(d == 32'h0, "R1 status after reset", int'(d), 0);

    // R2 readback
    wr(6'h00, 32'h0005_0001);
    rd(6'h00, d);
    chk(d == 32'h0005_0001, "R2 config readback", int'(d), 32'h50001);
    wr(6'h13, 32'h0000_1ABC);
    rd(6'h13, d);
    chk(d == 32'h1ABC, "R2 coefficient readback", int'(d), 32'h1ABC);

    // R3 directed roots
    begin
      int rr[] = '{5, 17, 40};
      build_from_roots(3, rr);
      trial(3, 64);
    end

    // R6 stale high coefficients
    begin
      int rr[] = '{3, 9};
      build_from_roots(2, rr);
      for (int k = 3; k <= MAX_T; k++) sg[k] = 13'h1000 | 13'(k * 77);
      trial(2, 30);
      rd(6'h03, d);
      chk(d[12:8] == 5'd2, "R6 stale terms ignored", int'(d[12:8]), 2);
    end

    // R5 saturation with a zero polynomial
    for (int k = 0; k <= MAX_T; k++) sg[k] = '0;
    trial(2, 10);
    trial(MAX_T, 12);

    // R9 zero length
    trial(3, 0);

    // R8 stop mid-search
    begin
      int rr[] = '{7};
      build_from_roots(1, rr);
      load_poly(1, 0);
      wr(6'h01, 32'd200);
      repeat (20) @(posedge clk);
      wr(6'h02, 32'h1);
      rd(6'h03, d);
      chk(d == 32'h0, "R8 status cleared by stop", int'(d), 0);
      repeat (250) @(posedge clk);
      #1 chk(search_done == 1'b0, "R8 no done after stop", int'(search_done), 0);
    end

    // R7 restart while busy
    begin
      int rr[] = '{11, 45};
      build_from_roots(2, rr);
      load_poly(2, 0);
      wr(6'h01, 32'd300);
      repeat (10) @(posedge clk);
      start_and_wait(50);
      rd(6'h03, d);
      chk(d[12:8] == 5'd2, "R7 restarted search count", int'(d[12:8]), 2);
    end

    // random trials
    for (int t = 0; t < 25; t++) begin
      int deg = 1 + int'($urandom % MAX_T);
      int len = 20 + int'($urandom % 230);
      int rr[] = new[deg];
      for (int i = 0; i < deg; i++) rr[i] = 1 + int'($urandom % (len + 20));
      if (t % 5 == 4) begin
        for (int k = 0; k <= MAX_T; k++) sg[k] = 13'($urandom);
      end else begin
        build_from_roots(deg, rr);
        for (int k = deg + 1; k <= MAX_T; k++) sg[k] = 13'($urandom);
      end
      trial(deg, len);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule